// File: doc/BRIEF.md
# Sixteen-bit Stack Machine Core

This block is a small processor that runs a stack-oriented macro instruction set held in a word-addressed main memory. Each instruction takes one fetch cycle, in which the word at the program counter is read into the instruction register and the program counter advances by one. The three highest bits of that word then select one of six operations, tested one bit at a time starting from bit 15. The stack lives in the same memory. The stack pointer always holds the address of the current top entry, and the stack grows toward higher addresses.

There is no stop instruction. A program ends when the program counter reaches a breakpoint address. The core then parks itself and stays still until reset. The memory port is synchronous. An address presented in one cycle returns its word on the read-data input in the next cycle. A write takes place at the clock edge on which the write enable is high. Status outputs show the program counter, the stack pointer and the accumulator, so an integrator can see the result of a program once the core halts.

Top module: `stk_machine`

## Requirements
- R1: While reset is high, and after it is released but before the first instruction, the program counter is 0, the stack pointer equals `sp_init`, the accumulator is 0, the core is not halted and no memory write is issued.
- R2: Each instruction begins with a read of the word at the program counter. The program counter then increases by exactly 1. The opcode is taken from instruction bits 15..13.
- R3: Opcode 000 (push) increments the stack pointer. It then writes the low 13 instruction bits, zero-extended to 16 bits, to memory at the new stack pointer.
- R4: Opcode 001 (pop) loads the word at the stack pointer into the accumulator and then decrements the stack pointer.
- R5: Opcode 100 (add) removes the top entry T. It replaces the entry below it, N, with (N + T) mod 2^16, leaves the stack pointer one lower, and leaves T in the accumulator.
- R6: Opcode 101 (subtract) removes T and replaces N with N − T. This result is computed as the one's complement of T plus N plus 1, mod 2^16. The stack pointer ends one lower and the accumulator holds T.
- R7: Opcode 110 (store) pops an address, then pops a data word. It writes the data word to that address and leaves the stack pointer two lower. The accumulator is unchanged.
- R8: Opcode 111 (fetch-indirect) replaces the top entry with the memory word whose address is the top entry. The stack pointer and the accumulator are unchanged.
- R9: Opcodes 010 and 011 do nothing beyond the fetch. The stack pointer, the accumulator and every memory word stay unchanged.
- R10: When `brk_en` is high and the program counter equals `brk_addr` at the start of an instruction, the core halts without executing the word at that address. It then issues no memory writes, and its program counter, stack pointer and accumulator stay frozen until reset.
- R11: The stack pointer wraps modulo 2^16. A push from 0xFFFF writes address 0, and a pop there returns the stack pointer to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sp_init | input | 16 | Stack pointer value loaded during reset |
| brk_en | input | 1 | Enables the halt-on-address breakpoint |
| brk_addr | input | 16 | Breakpoint instruction address |
| mem_addr | output | 16 | Main memory word address |
| mem_wdata | output | 16 | Main memory write data |
| mem_we | output | 1 | Main memory write enable |
| mem_rdata | input | 16 | Main memory read data, one cycle after the address |
| halted | output | 1 | High once the breakpoint has been reached |
| pc_o | output | 16 | Current program counter |
| sp_o | output | 16 | Current stack pointer |
| acc_o | output | 16 | Current accumulator |

## Verification
The bench sweeps add and subtract over pairs of operands that include 0, 0xFFFF, 0x7FFF and 0x8000. These pairs expose lost carries and reversed operand order: a core that computed T − N, or that dropped the +1 of the complement-and-add, would store the wrong word. Push is run with the widest 13-bit immediate, so any sign extension would show. Store is checked with its address and data roles in their defined order. A core that ran the two spare opcodes as real operations would change the stack or memory, and the bench compares the whole memory image after them. It also checks a breakpoint at the reset address and one in mid-program, where a core that ran the instruction at the breakpoint would leave an extra stack entry. A push across the 0xFFFF boundary checks the pointer wrap.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int OPC_W = 3;

    typedef enum logic [2:0] {
        K_PUSH, K_POP, K_NOP, K_ADD, K_SUB, K_STO, K_GET
    } op_e;

    typedef enum logic [3:0] {
        S_FETCH, S_LOAD_IR, S_DECODE, S_PUSH, S_RD_TOP,
        S_POP_DONE, S_RD_NEXT, S_GET_IND, S_WRITE, S_HALT
    } state_e;

    // Bit-serial style decode: the top bit is examined first, then the next.
    function automatic op_e decode_op(input logic [OPC_W-1:0] f);
        op_e r;
        if (f[2]) begin
            if (f[1]) r = f[0] ? K_GET : K_STO;
            else      r = f[0] ? K_SUB : K_ADD;
        end else begin
            if (f[1]) r = K_NOP;
            else      r = f[0] ? K_POP : K_PUSH;
        end
        return r;
    endfunction

endpackage

// File: rtl/stk_alu.sv
module stk_alu #(
    parameter int W = 16
) (
    input  logic         sub,
    input  logic [W-1:0] t,
    input  logic [W-1:0] n,
    output logic [W-1:0] y
);
    logic [W-1:0] t_sel;
    logic [W-1:0] cin;

    // Subtract reuses the adder: complement of the top plus carry-in of one.
    always_comb begin
        t_sel = sub ? ~t : t;
        cin   = {{(W-1){1'b0}}, sub};
        y     = n + t_sel + cin;
    end

    always_comb begin
        if (!sub) a_r5_add_ok : assert (y == n + t);
        else      a_r6_sub_ok : assert (y == n - t);
    end
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opc,
    input  logic             brk_hit,
    output state_e           state,
    output op_e              op,
    output logic             halted
);
    state_e nxt;

    assign op     = decode_op(opc);
    assign halted = (state == S_HALT);

    always_comb begin
        nxt = state;
        unique case (state)
            S_FETCH:    nxt = brk_hit ? S_HALT : S_LOAD_IR;
            S_LOAD_IR:  nxt = S_DECODE;
            S_DECODE: begin
                if (op == K_PUSH)     nxt = S_PUSH;
                else if (op == K_NOP) nxt = S_FETCH;
                else                  nxt = S_RD_TOP;
            end
            S_PUSH:     nxt = S_FETCH;
            S_RD_TOP: begin
                if (op == K_POP)      nxt = S_POP_DONE;
                else if (op == K_GET) nxt = S_GET_IND;
                else                  nxt = S_RD_NEXT;
            end
            S_POP_DONE: nxt = S_FETCH;
            S_RD_NEXT:  nxt = S_WRITE;
            S_GET_IND:  nxt = S_WRITE;
            S_WRITE:    nxt = S_FETCH;
            S_HALT:     nxt = S_HALT;
            default:    nxt = S_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_FETCH;
        else     state <= nxt;
    end

    a_r10_halt_sticky : assert property (@(posedge clk) disable iff (rst)
        (state == S_HALT) |=> (state == S_HALT));

    a_r9_spare_to_fetch : assert property (@(posedge clk) disable iff (rst)
        (state == S_DECODE && opc[2:1] == 2'b01) |=> (state == S_FETCH));
endmodule

// File: rtl/stk_dp.sv
module stk_dp
    import stk_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  state_e           state,
    input  op_e              op,
    input  logic [DW-1:0]    sp_init,
    input  logic             brk_en,
    input  logic [DW-1:0]    brk_addr,
    input  logic [DW-1:0]    mem_rdata,
    output logic [DW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             mem_we,
    output logic [OPC_W-1:0] opc,
    output logic             brk_hit,
    output logic [DW-1:0]    pc,
    output logic [DW-1:0]    sp,
    output logic [DW-1:0]    acc
);
    localparam int IMM_W = DW - OPC_W;
    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    logic [DW-1:0] ir;
    logic [DW-1:0] tmp;
    logic [DW-1:0] alu_y;
    logic [DW-1:0] imm_ext;

    assign opc     = ir[DW-1 -: OPC_W];
    assign imm_ext = {{OPC_W{1'b0}}, ir[IMM_W-1:0]};
    assign brk_hit = brk_en && (pc == brk_addr);

    stk_alu #(.W(DW)) u_alu (
        .sub (op == K_SUB),
        .t   (tmp),
        .n   (mem_rdata),
        .y   (alu_y)
    );

    always_comb begin
        mem_addr  = pc;
        mem_wdata = '0;
        mem_we    = 1'b0;
        unique case (state)
            S_FETCH:   mem_addr = pc;
            S_PUSH: begin
                mem_addr  = sp + ONE;
                mem_wdata = imm_ext;
                mem_we    = 1'b1;
            end
            S_RD_TOP:  mem_addr = sp;
            S_RD_NEXT: mem_addr = sp - ONE;
            S_GET_IND: mem_addr = mem_rdata;
            S_WRITE: begin
                mem_we = 1'b1;
                if (op == K_STO) begin
                    mem_addr  = tmp;
                    mem_wdata = mem_rdata;
                end else if (op == K_GET) begin
                    mem_addr  = sp;
                    mem_wdata = mem_rdata;
                end else begin
                    mem_addr  = sp;
                    mem_wdata = alu_y;
                end
            end
            default:   mem_addr = pc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            sp  <= sp_init;
            acc <= '0;
            ir  <= '0;
            tmp <= '0;
        end else begin
            unique case (state)
                S_LOAD_IR: begin
                    ir <= mem_rdata;
                    pc <= pc + ONE;
                end
                S_PUSH:     sp <= sp + ONE;
                S_POP_DONE: begin
                    acc <= mem_rdata;
                    sp  <= sp - ONE;
                end
                S_RD_NEXT: begin
                    tmp <= mem_rdata;
                    sp  <= sp - ONE;
                    if (op == K_ADD || op == K_SUB) acc <= mem_rdata;
                end
                S_WRITE: if (op == K_STO) sp <= sp - ONE;
                default: ;
            endcase
        end
    end

    a_r2_pc_step : assert property (@(posedge clk) disable iff (rst)
        (state == S_LOAD_IR) |=> (pc == $past(pc) + ONE));

    a_r3_push_zero_ext : assert property (@(posedge clk) disable iff (rst)
        (mem_we && state == S_PUSH) |-> (mem_wdata[DW-1 -: OPC_W] == '0));

    a_r8_get_keeps_sp : assert property (@(posedge clk) disable iff (rst)
        (state == S_WRITE && op == K_GET) |=> $stable(sp) && $stable(acc));

    a_r10_no_write_halted : assert property (@(posedge clk) disable iff (rst)
        (state == S_HALT) |-> !mem_we);

    a_r10_halt_frozen : assert property (@(posedge clk) disable iff (rst)
        (state == S_HALT) |=> ($stable(pc) && $stable(sp) && $stable(acc)));
endmodule

// File: rtl/stk_machine.sv
module stk_machine
    import stk_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] sp_init,
    input  logic          brk_en,
    input  logic [DW-1:0] brk_addr,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata,
    output logic          halted,
    output logic [DW-1:0] pc_o,
    output logic [DW-1:0] sp_o,
    output logic [DW-1:0] acc_o
);
    state_e           state;
    op_e              op;
    logic [OPC_W-1:0] opc;
    logic             brk_hit;

    stk_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .opc     (opc),
        .brk_hit (brk_hit),
        .state   (state),
        .op      (op),
        .halted  (halted)
    );

    stk_dp #(.DW(DW)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .op        (op),
        .sp_init   (sp_init),
        .brk_en    (brk_en),
        .brk_addr  (brk_addr),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .opc       (opc),
        .brk_hit   (brk_hit),
        .pc        (pc_o),
        .sp        (sp_o),
        .acc       (acc_o)
    );

    a_r1_reset_quiet : assert property (@(posedge clk)
        rst |=> (pc_o == '0 && acc_o == '0 && !halted && !mem_we));
endmodule

// File: tb/stk_machine_bench.sv
`timescale 1ns/1ps
module stk_machine_bench;
    localparam logic [2:0] P_PUSH = 3'b000, P_POP = 3'b001, P_ADD = 3'b100,
                           P_SUB = 3'b101, P_STO = 3'b110, P_GET = 3'b111;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] sp_init = 16'h00C0;
    logic        brk_en = 1'b1;
    logic [15:0] brk_addr = 16'h0005;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, halted;
    logic [15:0] pc_o, sp_o, acc_o;

    logic [15:0] mem [256];
    logic [15:0] exp_mem [256];
    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    stk_machine u_stk_machine (
        .clk(clk), .rst(rst), .sp_init(sp_init), .brk_en(brk_en),
        .brk_addr(brk_addr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted),
        .pc_o(pc_o), .sp_o(sp_o), .acc_o(acc_o)
    );

    always @(posedge clk) begin
        if (ld_en)       mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d cycles expected=completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [15:0] ins(input logic [2:0] op, input logic [12:0] imm);
        return {op, imm};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [15:0] d);
        ld_en = 1'b1;
        ld_addr = a[7:0];
        ld_data = d;
        exp_mem[a] = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic clear_mem();
        rst = 1'b1;
        for (int i = 0; i < 256; i++) put(i, 16'h0000);
    endtask

    task automatic run(input logic [15:0] spi, input logic [15:0] brk);
        sp_init = spi;
        brk_addr = brk;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (halted) break;
        end
        if (!halted) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 run end actual=running expected=halted");
        end
    endtask

    logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                              16'hFFFF, 16'h1234, 16'hA5A5, 16'h00FF};

    initial begin
        @(negedge clk);
        // R1: reset state
        clear_mem();
        chk("R1 pc", pc_o, 16'h0000);
        chk("R1 sp", sp_o, 16'h00C0);
        chk("R1 acc", acc_o, 16'h0000);
        chk("R1 halted", {15'd0, halted}, 16'h0000);
        chk("R1 we", {15'd0, mem_we}, 16'h0000);

        // R3 R4: push widest immediate, push, pop
        clear_mem();
        put(0, ins(P_PUSH, 13'h1FFF));
        put(1, ins(P_PUSH, 13'h0005));
        put(2, ins(P_POP, 13'h0));
        run(16'h00C0, 16'h0003);
        chk("R3 zero-extended push", mem[8'hC1], 16'h1FFF);
        chk("R3 second push", mem[8'hC2], 16'h0005);
        chk("R4 pop acc", acc_o, 16'h0005);
        chk("R4 pop sp", sp_o, 16'h00C1);
        chk("R2 pc at end", pc_o, 16'h0003);

        // R5 R6 R7 R8: sweep of add and subtract over operand pairs
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    clear_mem();
                    put(8'h40, vals[i]);
                    put(8'h41, vals[j]);
                    put(0, ins(P_PUSH, 13'h0040));
                    put(1, ins(P_GET, 13'h0));
                    put(2, ins(P_PUSH, 13'h0041));
                    put(3, ins(P_GET, 13'h0));
                    put(4, ins(s == 0 ? P_ADD : P_SUB, 13'h0));
                    put(5, ins(P_PUSH, 13'h0050));
                    put(6, ins(P_STO, 13'h0));
                    run(16'h00C0, 16'h0007);
                    if (s == 0) chk("R5 sum", mem[8'h50], vals[i] + vals[j]);
                    else        chk("R6 difference", mem[8'h50], vals[i] - vals[j]);
                    chk("R7 sp after store", sp_o, 16'h00C0);
                    chk("R5 R6 acc holds top", acc_o, vals[j]);
                end
            end
        end

        // R8: fetch-indirect
        clear_mem();
        put(8'h30, 16'hBEEF);
        put(0, ins(P_PUSH, 13'h0030));
        put(1, ins(P_GET, 13'h0));
        run(16'h00C0, 16'h0002);
        chk("R8 top replaced", mem[8'hC1], 16'hBEEF);
        chk("R8 sp", sp_o, 16'h00C1);
        chk("R8 acc", acc_o, 16'h0000);

        // R7: store order and acc untouched
        clear_mem();
        put(0, ins(P_PUSH, 13'h0AAA));
        put(1, ins(P_PUSH, 13'h0060));
        put(2, ins(P_STO, 13'h0));
        run(16'h00C0, 16'h0003);
        chk("R7 stored data", mem[8'h60], 16'h0AAA);
        chk("R7 sp", sp_o, 16'h00C0);
        chk("R7 acc", acc_o, 16'h0000);

        // R9: spare opcodes 010 and 011
        clear_mem();
        put(0, ins(P_PUSH, 13'h0007));
        put(1, 16'h4ABC);
        put(2, 16'h7FFF);
        run(16'h00C0, 16'h0003);
        exp_mem[8'hC1] = 16'h0007;
        begin
            int mism;
            mism = 0;
            for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) mism++;
            chk("R9 memory image mismatches", mism[15:0], 16'h0000);
        end
        chk("R9 sp", sp_o, 16'h00C1);
        chk("R9 acc", acc_o, 16'h0000);
        chk("R9 pc", pc_o, 16'h0003);

        // R10: breakpoint mid-program, then idle
        clear_mem();
        put(0, ins(P_PUSH, 13'h0005));
        put(1, ins(P_PUSH, 13'h0006));
        put(2, ins(P_PUSH, 13'h0007));
        run(16'h00C0, 16'h0002);
        for (int k = 0; k < 20; k++) @(negedge clk);
        chk("R10 pc frozen", pc_o, 16'h0002);
        chk("R10 sp frozen", sp_o, 16'h00C2);
        chk("R10 breakpoint word not run", mem[8'hC3], 16'h0000);
        chk("R10 halted", {15'd0, halted}, 16'h0001);

        // R10: breakpoint at reset address
        clear_mem();
        put(0, ins(P_PUSH, 13'h0009));
        run(16'h00C0, 16'h0000);
        chk("R10 reset bp sp", sp_o, 16'h00C0);
        chk("R10 reset bp memory", mem[8'hC1], 16'h0000);

        // R11: stack pointer wrap
        clear_mem();
        put(0, ins(P_PUSH, 13'h0123));
        put(1, ins(P_POP, 13'h0));
        run(16'hFFFF, 16'h0002);
        chk("R11 wrapped write at 0", mem[0], 16'h0123);
        chk("R11 pop acc", acc_o, 16'h0123);
        chk("R11 sp back", sp_o, 16'hFFFF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule